// File: doc/BRIEF.md
# Two-Level Interrupt Priority Arbiter

The block watches a set of interrupt request lines and every clock picks one winner among them. Each source has an enable bit and a 3-bit user level, both held in local registers. Software reads and writes these registers over a simple single-cycle register bus. A source competes only when its request line is high, its enable bit is set, its level is nonzero and its number is not a reserved slot. The highest user level wins. When several sources share that level, the one with the lowest source number wins.

The winning source number, its vector (source number plus a fixed offset) and its level are registered and presented one cycle after the request lines are sampled. A separate request output tells the processor to take the interrupt. It goes high only when the winning level is strictly above the current processor level that was sampled in the same cycle. Vector fetch, context saving and nesting are left to the processor. No pin carries a data stream, so the block has no valid/ready handshake. All pins are plain level signals with no back-pressure.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, every level field reads 4, every enable bit reads 0, and `win_valid`, `irq_req`, `win_src`, `win_vec` and `win_lvl` are all 0.
- R2: The level of source s sits in level register s/4 (bus address s/4), at bits [4*(s%4)+2 : 4*(s%4)]. Bit 4*(s%4)+3 always reads 0, even after a write of 1 to it.
- R3: The enable of source s sits at bus address NUM_PRIO_REGS + s/16 (14 for the default 54 sources), in bit s%16. Bits for source numbers at or above NUM_SRC always read 0.
- R4: A source takes part only when its request line and its enable bit are both 1 and its level is nonzero. A level of 0 never wins.
- R5: The winner is the taking-part source with the highest level, whatever its source number.
- R6: Among sources with the same highest level, the lowest source number wins.
- R7: `win_vec` equals `win_src` + 8 whenever `win_valid` is 1.
- R8: Reserved sources (4, 15, 23 to 26, 28, 33 to 36, 43 to 53) never win, even when requested, enabled and given level 7.
- R9: `irq_req` is 1 only when a winner exists and its level is strictly greater than `cpu_lvl`.
- R10: All outputs are registered. A change on `irq_pend` or `cpu_lvl` shows on the outputs after exactly one rising clock edge. When nothing takes part, `win_valid` is 0 and `win_src`, `win_vec` and `win_lvl` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | NUM_SRC | Request line of each source |
| cpu_lvl | input | 3 | Current processor level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_req | output | 1 | Interrupt request to the processor |
| win_valid | output | 1 | A winner exists |
| win_src | output | SRC_W | Winning source number |
| win_vec | output | VEC_W | Winning vector number |
| win_lvl | output | 3 | Winning level |

## Verification
The arbitration results (`win_valid`, `win_src`, `win_vec`, `win_lvl`, `irq_req`) are due one rising edge after `irq_pend` and `cpu_lvl` are applied. The bench drives its inputs on a falling edge, lets one rising edge pass, and samples on the next falling edge. A register write takes effect at the edge that accepts it, so any winner that depends on that write is due one edge later. The bench therefore finishes its writes and the following edge before it applies any arbitration vector. Read data is combinational and is sampled half a cycle after the address is driven.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W     = 3;
  localparam int REG_W     = 16;
  localparam int NIB_W     = 4;
  localparam int PER_REG   = REG_W / NIB_W;
  localparam int EN_PER_REG = REG_W;
  localparam logic [LVL_W-1:0] LVL_RESET = 3'd4;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 54,
  parameter int NUM_PRIO_REGS = 14,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  output lvl_t [NUM_SRC-1:0]       src_lvl,
  output logic [NUM_SRC-1:0]       src_en
);
  localparam logic [REG_W-1:0] PAD_MASK = 16'h8888;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        src_lvl[s] <= LVL_RESET;
        src_en[s]  <= 1'b0;
      end
    end else if (reg_wr) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (int'(reg_addr) == s / PER_REG)
          src_lvl[s] <= reg_wdata[NIB_W*(s%PER_REG) +: LVL_W];
        if (int'(reg_addr) == NUM_PRIO_REGS + s / EN_PER_REG)
          src_en[s] <= reg_wdata[s % EN_PER_REG];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (int'(reg_addr) == s / PER_REG)
        reg_rdata[NIB_W*(s%PER_REG) +: LVL_W] = src_lvl[s];
      if (int'(reg_addr) == NUM_PRIO_REGS + s / EN_PER_REG)
        reg_rdata[s % EN_PER_REG] = src_en[s];
    end
  end

  // R2: the top bit of every nibble in a level register reads back as 0
  a_r2_pad_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) < NUM_PRIO_REGS) |-> ((reg_rdata & PAD_MASK) == '0));
endmodule

// File: rtl/irq_pick_tree.sv
module irq_pick_tree
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 54,
  parameter int SRC_W = 6
) (
  input  logic [NUM_SRC-1:0]  live,
  input  lvl_t [NUM_SRC-1:0]  src_lvl,
  output logic                found,
  output logic [SRC_W-1:0]    best_src,
  output lvl_t                best_lvl
);
  // Scan from the highest index down. ">=" lets a lower index take over on a tie.
  always_comb begin
    best_lvl = '0;
    best_src = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i] && src_lvl[i] != '0 && src_lvl[i] >= best_lvl) begin
        best_lvl = src_lvl[i];
        best_src = SRC_W'(i);
      end
    end
    found = (best_lvl != '0);
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 54,
  parameter int VEC_OFS = 8,
  parameter logic [63:0] RSV_MASK = 64'h003F_F81E_1780_8010,
  localparam int NUM_PRIO_REGS = (NUM_SRC + PER_REG - 1) / PER_REG,
  localparam int NUM_EN_REGS = (NUM_SRC + EN_PER_REG - 1) / EN_PER_REG,
  localparam int ADDR_W = $clog2(NUM_PRIO_REGS + NUM_EN_REGS),
  localparam int SRC_W = $clog2(NUM_SRC),
  localparam int VEC_W = $clog2(NUM_SRC + VEC_OFS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_pend,
  input  logic [LVL_W-1:0]   cpu_lvl,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq_req,
  output logic               win_valid,
  output logic [SRC_W-1:0]   win_src,
  output logic [VEC_W-1:0]   win_vec,
  output logic [LVL_W-1:0]   win_lvl
);
  lvl_t [NUM_SRC-1:0] src_lvl;
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] live;
  logic               found;
  logic [SRC_W-1:0]   best_src;
  lvl_t               best_lvl;

  irq_cfg_regs #(
    .NUM_SRC(NUM_SRC), .NUM_PRIO_REGS(NUM_PRIO_REGS), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_lvl(src_lvl), .src_en(src_en)
  );

  assign live = irq_pend & src_en & ~RSV_MASK[NUM_SRC-1:0];

  irq_pick_tree #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_tree (
    .live(live), .src_lvl(src_lvl),
    .found(found), .best_src(best_src), .best_lvl(best_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_src   <= '0;
      win_vec   <= '0;
      win_lvl   <= '0;
      irq_req   <= 1'b0;
    end else begin
      win_valid <= found;
      win_src   <= found ? best_src : '0;
      win_vec   <= found ? VEC_W'(best_src) + VEC_W'(VEC_OFS) : '0;
      win_lvl   <= found ? best_lvl : '0;
      irq_req   <= found && (best_lvl > cpu_lvl);
    end
  end

  // R7: the vector tracks the source with the fixed offset
  a_r7_vector_offset: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (int'(win_vec) == int'(win_src) + VEC_OFS));
  // R8: a reserved slot is never reported as the winner
  a_r8_reserved_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> !RSV_MASK[win_src]);
  // R9: a request needs a level strictly above the processor level
  a_r9_req_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> ($past(win_valid) && $past(win_lvl) > $past(cpu_lvl, 2)));
  // R4: the reported winner was taking part one cycle earlier
  a_r4_winner_was_live: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ((($past(live) >> win_src) & 1) != 0));
  // R10: with no winner, the reported fields are zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (win_src == '0 && win_lvl == '0 && !irq_req));
endmodule

// File: tb/test_irq_level_arbiter.sv
module test_irq_level_arbiter;
  localparam int N = 54;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_pend = '0;
  logic [2:0]  cpu_lvl = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_req, win_valid;
  logic [5:0]  win_src, win_vec;
  logic [2:0]  win_lvl;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_level_arbiter i_irq_level_arbiter (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .cpu_lvl(cpu_lvl),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .win_valid(win_valid),
    .win_src(win_src), .win_vec(win_vec), .win_lvl(win_lvl)
  );

  // Fields: pend[77:14] cpu[13:11] valid[10] src[9:4] lvl[3:1] req[0]
  localparam int NV = 12;
  localparam logic [77:0] TBL [NV] = '{
    {64'h0,                   3'd0, 1'b0, 6'd0,  3'd0, 1'b0}, // R4 idle
    {64'h1,                   3'd0, 1'b1, 6'd0,  3'd1, 1'b1}, // R9 lvl1 > 0
    {64'h1,                   3'd1, 1'b1, 6'd0,  3'd1, 1'b0}, // R9 equal, no req
    {64'h9,                   3'd0, 1'b1, 6'd3,  3'd4, 1'b1}, // R5 level beats order
    {64'h2,                   3'd0, 1'b0, 6'd0,  3'd0, 1'b0}, // R4 level 0
    {64'h24,                  3'd6, 1'b1, 6'd2,  3'd7, 1'b1}, // R6 tie at 7
    {64'h1_0020,              3'd7, 1'b1, 6'd5,  3'd7, 1'b0}, // R5 / R9
    {64'h1_00C0,              3'd0, 1'b1, 6'd16, 3'd6, 1'b1}, // R5 level 6
    {64'h10,                  3'd0, 1'b0, 6'd0,  3'd0, 1'b0}, // R8 reserved 4
    {64'h0000_1000_0000_0040, 3'd0, 1'b1, 6'd6,  3'd4, 1'b1}, // R8 reserved 44 lvl7
    {64'h0020_0400_0000_0000, 3'd0, 1'b1, 6'd42, 3'd4, 1'b1}, // R8 53 vs 42
    {64'hC0,                  3'd3, 1'b1, 6'd6,  3'd4, 1'b1}  // R6 tie at 4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic apply(input logic [63:0] p, input logic [2:0] c);
    @(negedge clk);
    irq_pend = p[N-1:0]; cpu_lvl = c;
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", {31'd0, win_valid}, 0);
    chk("R1 req", {31'd0, irq_req}, 0);
    chk("R1 src", {26'd0, win_src}, 0);
    chk("R1 vec", {26'd0, win_vec}, 0);
    rst_n = 1'b1;
    rd(5'd0, d);  chk("R1 lvl reg0", {16'd0, d}, 32'h4444);
    rd(5'd13, d); chk("R1 lvl reg13", {16'd0, d}, 32'h0044);
    rd(5'd14, d); chk("R1 en reg", {16'd0, d}, 0);
    // R2 pad bits stay 0
    wr(5'd1, 16'hFFFF);
    rd(5'd1, d); chk("R2 pad bits", {16'd0, d}, 32'h7777);
    // configuration for the table
    wr(5'd0, 16'h4701);
    wr(5'd1, 16'h4474);
    wr(5'd4, 16'h4446);
    wr(5'd11, 16'h4447);
    for (int a = 14; a < 18; a++) wr(5'(a), 16'hFFFF);
    rd(5'd0, d);  chk("R2 reg0 fields", {16'd0, d}, 32'h4701);
    rd(5'd17, d); chk("R3 en top word", {16'd0, d}, 32'h003F);
    rd(5'd15, d); chk("R3 en word1", {16'd0, d}, 32'hFFFF);
    for (int k = 0; k < NV; k++) begin
      apply(TBL[k][77:14], TBL[k][13:11]);
      chk($sformatf("R10 valid v%0d", k), {31'd0, win_valid}, {31'd0, TBL[k][10]});
      chk($sformatf("R5 src v%0d", k), {26'd0, win_src}, {26'd0, TBL[k][9:4]});
      chk($sformatf("R5 lvl v%0d", k), {29'd0, win_lvl}, {29'd0, TBL[k][3:1]});
      chk($sformatf("R9 req v%0d", k), {31'd0, irq_req}, {31'd0, TBL[k][0]});
      chk($sformatf("R7 vec v%0d", k), {26'd0, win_vec},
          TBL[k][10] ? {26'd0, TBL[k][9:4]} + 32'd8 : 32'd0);
    end
    // R4 enable gating: turn off source 3 (address 14 bit 3)
    wr(5'd14, 16'hFFF7);
    apply(64'h9, 3'd0);
    chk("R4 disabled src3", {26'd0, win_src}, 0);
    chk("R4 disabled lvl", {29'd0, win_lvl}, 1);
    // R10 latency: outputs hold until one edge after the change
    @(negedge clk);
    irq_pend = N'(64'h24); cpu_lvl = 3'd0;
    #1 chk("R10 no early change", {26'd0, win_src}, 0);
    @(negedge clk);
    chk("R10 one edge later", {26'd0, win_src}, 2);
    // R7 highest valid vector: source 42 gives vector 50
    apply(64'h0000_0400_0000_0000, 3'd0);
    chk("R7 vec src42", {26'd0, win_vec}, 50);
    // R8 reserved 15 with level 7
    wr(5'd3, 16'h7444);
    apply(64'h8000, 3'd0);
    chk("R8 reserved 15", {31'd0, win_valid}, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule